// File: doc/BRIEF.md
# Whole-Line Write Detector for a Miss Entry

This block watches the requests merged into one outstanding cache-miss entry. It decides whether the entry holds nothing but plain writes, and whether those writes together cover every byte of the cache line. When both hold, the miss can be sent downstream as a full-line write, and no fill data needs to be fetched.

On allocation the entry takes the block address and starts from a clean state. After that it accepts at most one target request per clock. Each request carries a write flag, an address whose low bits give the byte offset, a byte count, a source tag and eight attribute flags. The block keeps a one-bit-per-byte coverage map and a sticky flag that records whether every request so far was a mergeable write. A live indication follows these two pieces of state. When the miss is marked in service, the live value is captured into a registered flag. The fill then makes the same decision even if more requests arrive after the miss was sent.

Top module: `fullline_write_detect`

## Requirements
- R1: Reset, or an `alloc_i` pulse, leaves the coverage map all clear, the write-only flag true and the issued flag false. `clean_o` is high and both result outputs are low on the cycle after the edge.
- R2: A request is mergeable only when `req_write_i` is 1 and every bit of `req_attr_i` is 0. The attribute bits are: bit0 uncacheable, bit1 strict order, bit2 memory-mapped register, bit3 privileged, bit4 load-linked/store-conditional, bit5 swap, bit6 conditional swap, bit7 secure.
- R3: A tracked request that is not mergeable clears the write-only flag. The flag stays clear until the next allocation, so later writes never make `full_write_o` high.
- R4: While the write-only flag is true, a mergeable write sets the map bits from offset (the low log2(LINE_BYTES) bits of `req_addr_i`) through offset+size-1. A size of 0 sets nothing.
- R5: A write that would run past the last byte of the line is clipped at that last byte.
- R6: Once `full_write_o` is high, later requests (reads included) change neither the flag nor the map, and `full_write_o` stays high until allocation.
- R7: A request with `req_src_i` = 2 (prefetcher) leaves all tracking state unchanged. Source 0 is the core and source 1 is an upper cache.
- R8: `full_write_o` is high exactly when the write-only flag is true and every map bit is set. It changes on the edge that takes the completing request.
- R9: On `issue_i`, `issued_full_write_o` captures the whole-line value, including a request taken on the same edge. It then holds that value while later requests arrive, until allocation clears it.
- R10: `clean_o` is high exactly when the write-only flag is true and no map bit is set.
- R11: When `alloc_i` and a request or `issue_i` arrive on the same edge, allocation wins: the request is dropped and the issued flag is cleared. `line_addr_o` holds the allocated address with its offset bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_i | input | 1 | Allocate / re-initialise the entry |
| alloc_addr_i | input | ADDR_W | Address given at allocation |
| req_valid_i | input | 1 | A target request is present this cycle |
| req_write_i | input | 1 | The request is a write |
| req_addr_i | input | ADDR_W | Request address; low bits are the byte offset |
| req_size_i | input | SIZE_W | Byte count (0 to LINE_BYTES) |
| req_src_i | input | 2 | Source: 0 core, 1 upper cache, 2 prefetcher |
| req_attr_i | input | 8 | Attribute flags (see R2) |
| issue_i | input | 1 | The miss is marked in service |
| line_addr_o | output | ADDR_W | Block address of the entry |
| full_write_o | output | 1 | Live whole-line-write indication |
| issued_full_write_o | output | 1 | Whole-line value latched at issue |
| clean_o | output | 1 | Entry is in its allocation state |

## Verification
A map bit that is stuck or set wrongly shows in two ways. Either `full_write_o` rises one edge too early or never rises, or `clean_o` drops after a write that should have been filtered out. Both are visible on the cycle after the request. A write-only flag that recovers without an allocation shows up when a write that completes coverage after a read makes `full_write_o` rise. A latch that samples the wrong value shows on `issued_full_write_o` on the cycle after `issue_i`, or later when it follows the live value it should have frozen. The scoreboard compares all three flags after every operation, so each of these faults surfaces within one cycle of its cause.

// File: rtl/lwd_pkg.sv
package lwd_pkg;
   localparam int ATTR_W = 8;

   typedef enum logic [1:0] {
      SRC_CORE     = 2'd0,
      SRC_UPPER    = 2'd1,
      SRC_PREFETCH = 2'd2
   } req_src_e;

   // bit positions of the attribute vector; any set bit blocks merging
   localparam int ATTR_UNCACHED   = 0;
   localparam int ATTR_STRICT     = 1;
   localparam int ATTR_MMREG      = 2;
   localparam int ATTR_PRIV       = 3;
   localparam int ATTR_LLSC       = 4;
   localparam int ATTR_SWAP       = 5;
   localparam int ATTR_SWAP_COND  = 6;
   localparam int ATTR_SECURE     = 7;
endpackage

// File: rtl/lwd_byte_mask.sv
module lwd_byte_mask #(
   parameter int LINE_BYTES = 64,
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int SIZE_W = OFF_W + 1
) (
   input  logic [OFF_W-1:0]      off_i,
   input  logic [SIZE_W-1:0]     size_i,
   output logic [LINE_BYTES-1:0] mask_o
);
   logic [SIZE_W:0] end_excl;

   // end is one past the last byte; bytes beyond the line simply do not exist
   assign end_excl = {2'b00, off_i} + {1'b0, size_i};

   for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
      localparam logic [SIZE_W:0] IDX = (SIZE_W+1)'(b);
      assign mask_o[b] = (IDX >= {2'b00, off_i}) && (IDX < end_excl);
   end
endmodule

// File: rtl/lwd_cover_map.sv
module lwd_cover_map #(
   parameter int LINE_BYTES = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear_i,
   input  logic                  set_en_i,
   input  logic [LINE_BYTES-1:0] mask_i,
   output logic [LINE_BYTES-1:0] cov_q_o,
   output logic [LINE_BYTES-1:0] cov_next_o,
   output logic                  all_q_o,
   output logic                  all_next_o,
   output logic                  none_q_o
);
   for (genvar b = 0; b < LINE_BYTES; b++) begin : g_bit
      always_comb begin
         if (clear_i)
            cov_next_o[b] = 1'b0;
         else if (set_en_i && mask_i[b])
            cov_next_o[b] = 1'b1;
         else
            cov_next_o[b] = cov_q_o[b];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cov_q_o[b] <= 1'b0;
         else
            cov_q_o[b] <= cov_next_o[b];
      end
   end

   assign all_q_o    = &cov_q_o;
   assign all_next_o = &cov_next_o;
   assign none_q_o   = ~|cov_q_o;
endmodule

// File: rtl/lwd_ctrl.sv
module lwd_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic alloc_i,
   input  logic track_i,
   input  logic mergeable_i,
   input  logic issue_i,
   input  logic all_next_i,
   output logic only_q_o,
   output logic only_next_o,
   output logic issued_q_o
);
   logic issued_next;

   always_comb begin
      if (alloc_i)
         only_next_o = 1'b1;
      else if (track_i && !mergeable_i)
         only_next_o = 1'b0;
      else
         only_next_o = only_q_o;
   end

   // issue samples the post-request value so a same-edge request counts
   always_comb begin
      if (alloc_i)
         issued_next = 1'b0;
      else if (issue_i)
         issued_next = only_next_o && all_next_i;
      else
         issued_next = issued_q_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         only_q_o   <= 1'b1;
         issued_q_o <= 1'b0;
      end else begin
         only_q_o   <= only_next_o;
         issued_q_o <= issued_next;
      end
   end
endmodule

// File: rtl/fullline_write_detect.sv
module fullline_write_detect #(
   parameter int LINE_BYTES = 64,
   parameter int ADDR_W     = 32,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int SIZE_W    = OFF_W + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      alloc_i,
   input  logic [ADDR_W-1:0]         alloc_addr_i,
   input  logic                      req_valid_i,
   input  logic                      req_write_i,
   input  logic [ADDR_W-1:0]         req_addr_i,
   input  logic [SIZE_W-1:0]         req_size_i,
   input  logic [1:0]                req_src_i,
   input  logic [lwd_pkg::ATTR_W-1:0] req_attr_i,
   input  logic                      issue_i,
   output logic [ADDR_W-1:0]         line_addr_o,
   output logic                      full_write_o,
   output logic                      issued_full_write_o,
   output logic                      clean_o
);
   import lwd_pkg::*;

   initial begin
      assert (LINE_BYTES >= 2 && (LINE_BYTES & (LINE_BYTES - 1)) == 0)
         else $error("LINE_BYTES must be a power of two of at least 2");
      assert (ADDR_W > OFF_W)
         else $error("ADDR_W must exceed the offset width");
   end

   logic [LINE_BYTES-1:0] mask, cov_q, cov_next;
   logic all_q, all_next, none_q;
   logic only_q, only_next;
   logic frozen, track, mergeable, set_en;

   assign frozen    = only_q && all_q;
   assign track     = req_valid_i && !alloc_i && !frozen &&
                      (req_src_i != SRC_PREFETCH);
   assign mergeable = req_write_i && (req_attr_i == '0);
   assign set_en    = track && mergeable && only_q;

   lwd_byte_mask #(.LINE_BYTES(LINE_BYTES)) u_mask (
      .off_i  (req_addr_i[OFF_W-1:0]),
      .size_i (req_size_i),
      .mask_o (mask)
   );

   lwd_cover_map #(.LINE_BYTES(LINE_BYTES)) u_map (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (alloc_i),
      .set_en_i   (set_en),
      .mask_i     (mask),
      .cov_q_o    (cov_q),
      .cov_next_o (cov_next),
      .all_q_o    (all_q),
      .all_next_o (all_next),
      .none_q_o   (none_q)
   );

   lwd_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_i     (alloc_i),
      .track_i     (track),
      .mergeable_i (mergeable),
      .issue_i     (issue_i),
      .all_next_i  (all_next),
      .only_q_o    (only_q),
      .only_next_o (only_next),
      .issued_q_o  (issued_full_write_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         line_addr_o <= '0;
      else if (alloc_i)
         line_addr_o <= {alloc_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   end

   assign full_write_o = frozen;
   assign clean_o      = only_q && none_q;
endmodule

// File: rtl/lwd_checker.sv
module lwd_checker #(
   parameter int LINE_BYTES = 64
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  alloc_i,
   input logic                  issue_i,
   input logic                  req_valid_i,
   input logic [1:0]            req_src_i,
   input logic                  full_write_o,
   input logic                  issued_full_write_o,
   input logic                  clean_o,
   input logic                  only_q,
   input logic [LINE_BYTES-1:0] cov_q
);
   a_r1_alloc_clean: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |=> clean_o && !issued_full_write_o && !full_write_o);

   a_r3_sticky_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !only_q && !alloc_i |=> !only_q);

   a_r6_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
      full_write_o && !alloc_i |=> full_write_o && $stable(cov_q));

   a_r7_prefetch_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i && req_src_i == 2'd2 && !alloc_i |=> $stable(cov_q) && $stable(only_q));

   a_r9_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_i && !alloc_i |=> $stable(issued_full_write_o));
endmodule

bind fullline_write_detect lwd_checker #(.LINE_BYTES(LINE_BYTES)) u_lwd_checker (
   .clk                 (clk),
   .rst_n               (rst_n),
   .alloc_i             (alloc_i),
   .issue_i             (issue_i),
   .req_valid_i         (req_valid_i),
   .req_src_i           (req_src_i),
   .full_write_o        (full_write_o),
   .issued_full_write_o (issued_full_write_o),
   .clean_o             (clean_o),
   .only_q              (only_q),
   .cov_q               (cov_q)
);

// File: tb/test_fullline_write_detect.sv
module test_fullline_write_detect;
   localparam int CLK_PERIOD = 10;
   localparam int LB = 64;
   localparam int AW = 32;
   localparam int SW = $clog2(LB) + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic alloc = 1'b0, valid = 1'b0, wr = 1'b0, issue = 1'b0;
   logic [AW-1:0] aaddr = '0, raddr = '0;
   logic [SW-1:0] size = '0;
   logic [1:0] src = '0;
   logic [7:0] attr = '0;
   logic [AW-1:0] line_addr;
   logic full, issued, clean;

   always #(CLK_PERIOD/2) clk = ~clk;

   fullline_write_detect #(.LINE_BYTES(LB), .ADDR_W(AW)) i_fullline_write_detect (
      .clk(clk), .rst_n(rst_n), .alloc_i(alloc), .alloc_addr_i(aaddr),
      .req_valid_i(valid), .req_write_i(wr), .req_addr_i(raddr),
      .req_size_i(size), .req_src_i(src), .req_attr_i(attr), .issue_i(issue),
      .line_addr_o(line_addr), .full_write_o(full),
      .issued_full_write_o(issued), .clean_o(clean)
   );

   typedef struct {
      bit    full;
      bit    iss;
      bit    clean;
      string tag;
   } exp_t;
   exp_t sb[$];

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // reference model of the requirements
   bit          m_only = 1'b1;
   bit [LB-1:0] m_cov  = '0;
   bit          m_iss  = 1'b0;

   function automatic void model(bit a, bit v, bit w, int off, int sz,
                                 int s, int at, bit is);
      if (a) begin
         m_only = 1'b1; m_cov = '0; m_iss = 1'b0;
         return;
      end
      if (v && s != 2 && !(m_only && (&m_cov))) begin
         m_only = m_only && w && (at == 0);
         if (m_only)
            for (int i = 0; i < LB; i++)
               if (i >= off && i < off + sz) m_cov[i] = 1'b1;
      end
      if (is) m_iss = m_only && (&m_cov);
   endfunction

   task automatic push(string tag);
      exp_t e;
      e.full  = m_only && (&m_cov);
      e.iss   = m_iss;
      e.clean = m_only && (m_cov == '0);
      e.tag   = tag;
      sb.push_back(e);
   endtask

   task automatic op(bit a, bit v, bit w, int off, int sz, int s, int at,
                     bit is, string tag);
      @(negedge clk);
      alloc = a; valid = v; wr = w; raddr = AW'(32'h1000 + off);
      size = SW'(sz); src = 2'(s); attr = 8'(at); issue = is;
      aaddr = 32'h0000_1234;
      @(posedge clk);
      #1;
      alloc = 1'b0; valid = 1'b0; issue = 1'b0;
      model(a, v, w, off, sz, s, at, is);
      push(tag);
   endtask

   task automatic wr8(int off, string tag);
      op(0, 1, 1, off, 8, 0, 0, 0, tag);
   endtask

   // monitor: compare outputs against the queued expectations
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (full !== e.full || issued !== e.iss || clean !== e.clean) begin
            fails++;
            $display("FAIL %s: full/issued/clean = %b%b%b expected %b%b%b",
                     e.tag, full, issued, clean, e.full, e.iss, e.clean);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      push("R1 reset state");

      // R1 R11 allocation and line address
      op(1, 0, 0, 0, 0, 0, 0, 0, "R1 alloc");
      @(negedge clk);
      checks++;
      if (line_addr !== 32'h0000_1200) begin
         fails++;
         $display("FAIL R11 line_addr: %h expected %h", line_addr, 32'h0000_1200);
      end

      // R4 R8 full cover built from 8-byte writes; R10 clean drops
      for (int k = 0; k < 7; k++) wr8(k * 8, "R4 R10 partial cover");
      wr8(56, "R8 completing write");
      // R6 a read after full coverage is ignored
      op(0, 1, 0, 0, 4, 0, 0, 0, "R6 read after full");
      // R9 latch at issue, stays through later requests
      op(0, 0, 0, 0, 0, 0, 0, 1, "R9 issue latch");
      op(0, 1, 1, 0, 4, 0, 1, 0, "R9 R6 later request");

      // R3 read first, later writes never complete
      op(1, 0, 0, 0, 0, 0, 0, 0, "R1 realloc");
      op(0, 1, 0, 0, 4, 1, 0, 0, "R3 read clears flag");
      for (int k = 0; k < 8; k++) wr8(k * 8, "R3 writes after read");

      // R2 each attribute bit blocks merging
      for (int b = 0; b < 8; b++) begin
         op(1, 0, 0, 0, 0, 0, 0, 0, "R1 realloc");
         op(0, 1, 1, 0, 64, 0, 1 << b, 0, "R2 attribute blocks merge");
      end

      // R7 prefetcher covering bytes 0..7 does not count
      op(1, 0, 0, 0, 0, 0, 0, 0, "R1 realloc");
      op(0, 1, 1, 0, 8, 2, 0, 0, "R7 prefetch write");
      op(0, 1, 0, 0, 8, 2, 0, 0, "R7 prefetch read");
      op(0, 1, 1, 8, 56, 0, 0, 0, "R7 rest of line");
      wr8(0, "R7 real write completes");

      // R5 clipping at line end, R4 size zero
      op(1, 0, 0, 0, 0, 0, 0, 0, "R1 realloc");
      op(0, 1, 1, 0, 0, 0, 0, 0, "R4 size zero");
      op(0, 1, 1, 60, 8, 0, 0, 0, "R5 clipped write");
      op(0, 1, 1, 0, 60, 0, 0, 0, "R5 low part completes");

      // R9 same-edge request and issue: latched value includes the request
      op(1, 0, 0, 0, 0, 0, 0, 0, "R1 realloc");
      op(0, 1, 1, 0, 32, 0, 0, 0, "R9 half");
      op(0, 1, 1, 32, 32, 0, 0, 1, "R9 same-edge issue");

      // R9 issue before full: latch stays 0 while live rises
      op(1, 0, 0, 0, 0, 0, 0, 0, "R1 realloc");
      op(0, 1, 1, 0, 32, 0, 0, 1, "R9 early issue");
      op(0, 1, 1, 32, 32, 0, 0, 0, "R9 live rises latch holds");

      // R11 alloc wins over same-edge request and issue
      op(1, 1, 0, 0, 4, 0, 0, 1, "R11 alloc priority");
      op(0, 1, 1, 0, 64, 0, 0, 0, "R11 entry still write-only");

      @(negedge clk);
      @(negedge clk);
      finish_run();
   end
endmodule